// File: doc/BRIEF.md
# Self-Synchronizing Bit Scrambler / Descrambler

This block whitens or restores a serial bit stream with a two-tap feedback shift register. One module covers both directions. A compile-time mode parameter picks the direction, and the only difference between the two is what enters the register. In scramble mode the register takes in each coded bit it emits. In descramble mode it takes in each received line bit. Each output bit is the input bit XORed with two stages of the register: the middle tap and the last stage.

A bit is processed only on cycles where the input strobe is high. The coded bit and its strobe appear one cycle later, so each input bit gives exactly one output bit. A synchronous reset loads the register from a seed input. The register contents are brought out so that the seed and the shift pattern can be observed.

Because the descrambler history is built only from line bits, two things follow. A descrambler with the wrong seed is correct again once STAGES valid bits have passed. A single line error corrupts a fixed, bounded set of decoded bits.

Top module: `ssync_scrambler`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads `seed`, and after that edge `dout` and `dout_vld` are 0.
- R2: Stages are numbered 1 (newest) to STAGES (oldest), and stage k appears on `state_o[k-1]`. After a valid input bit `d`, `dout` becomes `d ^ stage[TAP_MID] ^ stage[STAGES]`, using the register contents from before the shift.
- R3: On a valid bit the register shifts by one place toward the oldest stage. Stage 1 takes the coded output bit in scramble mode (`DESCRAMBLE=0`) and the raw input bit in descramble mode (`DESCRAMBLE=1`).
- R4: When `din_vld` is low, `state_o` and `dout` keep their values.
- R5: `dout_vld` equals `din_vld` delayed by one clock, so there is exactly one output bit per input bit.
- R6: A descrambler seeded the same as the scrambler and fed the scrambler's output reproduces the original data bit for bit.
- R7: A descrambler with a seed different from the scrambler's reproduces the original data correctly from the (STAGES+1)-th valid bit onward.
- R8: One inverted line bit gives exactly three decoded errors: at the bit itself, TAP_MID bits later and STAGES bits later.
- R9: An all-zero seed with all-zero input gives all-zero output. With the default taps (7, 6), a non-zero seed and all-zero input give an output of period 127 that holds 64 ones per period, and the register returns to the seed after 127 bits.
- R10: When reset and a valid bit arrive in the same cycle, the reset wins: the register holds `seed` and `dout_vld` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the seed |
| seed | input | STAGES | Register value loaded on reset |
| din | input | 1 | Serial data input (plain data or line bits) |
| din_vld | input | 1 | Input bit strobe |
| dout | output | 1 | Serial coded or decoded output, registered |
| dout_vld | output | 1 | Output strobe, one cycle after `din_vld` |
| state_o | output | STAGES | Register contents; bit k-1 is stage k |

## Verification
Seed loading and the data shift can fall in the same cycle. The bench provokes this by raising `rst` together with `din_vld` and a data bit of 1. It judges the result by checking that `state_o` equals the seed rather than a shifted value, and that `dout_vld` stays low. Within the shift path, the coded-bit computation and the register feed also share every valid cycle. In scramble mode the feed is the freshly computed bit, so each cycle's `dout` and `state_o[0]` are compared against an independent model of both.

// File: rtl/ssync_pkg.sv
package ssync_pkg;
  // feedback from the two taps
  function automatic logic tap_sum(input logic mid_bit, input logic far_bit);
    return mid_bit ^ far_bit;
  endfunction

  // combine a data bit with the feedback
  function automatic logic code_bit(input logic data_bit, input logic fb);
    return data_bit ^ fb;
  endfunction

  // one shift step: new bit enters stage 1 (index 0)
  function automatic logic [63:0] shift_in(input logic [63:0] cur, input logic nb);
    return {cur[62:0], nb};
  endfunction
endpackage

// File: rtl/ssync_history.sv
module ssync_history #(
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] seed,
  input  logic              adv,
  input  logic              feed,
  output logic [STAGES-1:0] hist
);
  logic [63:0] widened;
  logic [63:0] shifted;

  always_comb begin
    widened = '0;
    widened[STAGES-1:0] = hist;
    shifted = ssync_pkg::shift_in(widened, feed);
  end

  always_ff @(posedge clk) begin
    if (rst)      hist <= seed;
    else if (adv) hist <= shifted[STAGES-1:0];
  end
endmodule

// File: rtl/ssync_tap_mix.sv
module ssync_tap_mix #(
  parameter int STAGES     = 7,
  parameter int TAP_MID    = 6,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic [STAGES-1:0] hist,
  input  logic              din,
  output logic              tap_mid_bit,
  output logic              tap_far_bit,
  output logic              coded,
  output logic              feed
);
  logic fb;

  assign tap_mid_bit = hist[TAP_MID-1];
  assign tap_far_bit = hist[STAGES-1];
  assign fb          = ssync_pkg::tap_sum(tap_mid_bit, tap_far_bit);
  assign coded       = ssync_pkg::code_bit(din, fb);

  generate
    if (DESCRAMBLE) begin : g_line_feed
      assign feed = din;
    end else begin : g_coded_feed
      assign feed = coded;
    end
  endgenerate
endmodule

// File: rtl/ssync_out_stage.sv
module ssync_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic coded,
  output logic dout,
  output logic dout_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= adv;
      if (adv) dout <= coded;
    end
  end
endmodule

// File: rtl/ssync_scrambler.sv
module ssync_scrambler #(
  parameter int STAGES     = 7,
  parameter int TAP_MID    = 6,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] seed,
  input  logic              din,
  input  logic              din_vld,
  output logic              dout,
  output logic              dout_vld,
  output logic [STAGES-1:0] state_o
);
  localparam bool_ok = (TAP_MID > 0) && (TAP_MID < STAGES) && (STAGES <= 64);

  generate
    if (!bool_ok) begin : g_bad_taps
      $error("ssync_scrambler: need 0 < TAP_MID < STAGES <= 64");
    end
  endgenerate

  logic              shift_en;
  logic              coded;
  logic              feed;
  logic              tap_mid_bit;
  logic              tap_far_bit;
  logic [STAGES-1:0] hist;

  assign shift_en = din_vld;

  ssync_history #(.STAGES(STAGES)) u_hist (
    .clk (clk),
    .rst (rst),
    .seed(seed),
    .adv (shift_en),
    .feed(feed),
    .hist(hist)
  );

  ssync_tap_mix #(.STAGES(STAGES), .TAP_MID(TAP_MID), .DESCRAMBLE(DESCRAMBLE)) u_mix (
    .hist       (hist),
    .din        (din),
    .tap_mid_bit(tap_mid_bit),
    .tap_far_bit(tap_far_bit),
    .coded      (coded),
    .feed       (feed)
  );

  ssync_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .adv     (shift_en),
    .coded   (coded),
    .dout    (dout),
    .dout_vld(dout_vld)
  );

  assign state_o = hist;
endmodule

// File: rtl/ssync_scrambler_chk.sv
module ssync_scrambler_chk #(
  parameter int STAGES     = 7,
  parameter int TAP_MID    = 6,
  parameter bit DESCRAMBLE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [STAGES-1:0] seed,
  input logic              din,
  input logic              din_vld,
  input logic              dout,
  input logic              dout_vld,
  input logic [STAGES-1:0] state_o
);
  // R1 and R10: reset loads the seed and wins over a valid bit
  assert_seed_load_R1: assert property (@(posedge clk)
    rst |=> (state_o == $past(seed)) && !dout_vld && !dout);

  assert_coded_bit_R2: assert property (@(posedge clk) disable iff (rst)
    din_vld |=> dout == ($past(din) ^ $past(state_o[TAP_MID-1]) ^ $past(state_o[STAGES-1])));

  assert_shift_feed_R3: assert property (@(posedge clk) disable iff (rst)
    din_vld |=> (state_o[STAGES-1:1] == $past(state_o[STAGES-2:0]))
                && (state_o[0] == (DESCRAMBLE ? $past(din) : dout)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> $stable(state_o) && $stable(dout));

  assert_vld_follow_R5: assert property (@(posedge clk) disable iff (rst)
    din_vld |=> dout_vld);

  assert_no_spurious_vld_R5: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> !dout_vld);
endmodule

bind ssync_scrambler ssync_scrambler_chk #(
  .STAGES(STAGES), .TAP_MID(TAP_MID), .DESCRAMBLE(DESCRAMBLE)
) u_chk (
  .clk(clk), .rst(rst), .seed(seed), .din(din), .din_vld(din_vld),
  .dout(dout), .dout_vld(dout_vld), .state_o(state_o)
);

// File: tb/ssync_scrambler_bench.sv
module ssync_scrambler_bench;
  localparam int N = 7;
  localparam int M = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1;
  logic [N-1:0] seed_s = '0, seed_d = '0;
  logic         s_din = 1'b0, s_vld = 1'b0, d_din = 1'b0, d_vld = 1'b0;
  logic         s_dout, s_ovld, d_dout, d_ovld;
  logic [N-1:0] s_state, d_state;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench models: index 1 is the newest stage
  logic ms [1:N];
  logic md [1:N];
  logic es, ed, ev;

  ssync_scrambler #(.STAGES(N), .TAP_MID(M), .DESCRAMBLE(1'b0)) u_ssync_scrambler (
    .clk(clk), .rst(rst), .seed(seed_s), .din(s_din), .din_vld(s_vld),
    .dout(s_dout), .dout_vld(s_ovld), .state_o(s_state)
  );

  ssync_scrambler #(.STAGES(N), .TAP_MID(M), .DESCRAMBLE(1'b1)) u_ssync_descrambler (
    .clk(clk), .rst(rst), .seed(seed_d), .din(d_din), .din_vld(d_vld),
    .dout(d_dout), .dout_vld(d_ovld), .state_o(d_state)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pack_s();
    logic [N-1:0] r;
    for (int k = 1; k <= N; k++) r[k-1] = ms[k];
    return r;
  endfunction

  function automatic logic [N-1:0] pack_d();
    logic [N-1:0] r;
    for (int k = 1; k <= N; k++) r[k-1] = md[k];
    return r;
  endfunction

  function automatic logic predict_line(input logic x);
    return x ^ ms[M] ^ ms[N];
  endfunction

  task automatic do_reset(input logic [N-1:0] ss, input logic [N-1:0] sd, input logic vld, input string req);
    @(negedge clk);
    rst = 1'b1; seed_s = ss; seed_d = sd;
    s_vld = vld; d_vld = vld; s_din = 1'b1; d_din = 1'b1;
    @(posedge clk); #2;
    for (int k = 1; k <= N; k++) begin ms[k] = ss[k-1]; md[k] = sd[k-1]; end
    es = 1'b0; ed = 1'b0; ev = 1'b0;
    check(req, "scr state after reset", s_state, ss);
    check(req, "dsc state after reset", d_state, sd);
    check(req, "scr dout_vld after reset", s_ovld, 1'b0);
    check(req, "dsc dout after reset", d_dout, 1'b0);
    @(negedge clk);
    rst = 1'b0; s_vld = 1'b0; d_vld = 1'b0; s_din = 1'b0; d_din = 1'b0;
  endtask

  // drive one bit to both instances and compare against the models
  task automatic push(input logic x, input logic line, input logic v);
    @(negedge clk);
    s_din = x; d_din = line; s_vld = v; d_vld = v;
    if (v) begin
      es = x ^ ms[M] ^ ms[N];
      for (int k = N; k > 1; k--) ms[k] = ms[k-1];
      ms[1] = es;
      ed = line ^ md[M] ^ md[N];
      for (int k = N; k > 1; k--) md[k] = md[k-1];
      md[1] = line;
    end
    ev = v;
    @(posedge clk); #2;
    check("R2", "scr dout", s_dout, es);
    check("R2", "dsc dout", d_dout, ed);
    check("R3", "scr state", s_state, pack_s());
    check("R3", "dsc state", d_state, pack_d());
    check("R5", "scr dout_vld", s_ovld, ev);
    check("R5", "dsc dout_vld", d_ovld, ev);
  endtask

  task automatic t_reset_R1();
    do_reset(7'h5A, 7'h13, 1'b0, "R1");
  endtask

  task automatic t_patterns_R2();
    logic x;
    do_reset(7'h01, 7'h7F, 1'b0, "R1");
    for (int i = 0; i < 60; i++) begin
      x = (i < 20) ? 1'b1 : (i < 40) ? logic'(i % 2) : logic'($urandom_range(0, 1));
      push(x, logic'($urandom_range(0, 1)), 1'b1);
    end
  endtask

  task automatic t_gaps_R4();
    logic [N-1:0] held;
    do_reset(7'h2C, 7'h41, 1'b0, "R1");
    for (int i = 0; i < 30; i++) begin
      push(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)), 1'b1);
      held = s_state;
      push(1'b1, 1'b1, 1'b0);
      check("R4", "scr state held on idle", s_state, held);
    end
  endtask

  task automatic t_loopback_R6();
    logic x;
    do_reset(7'h33, 7'h33, 1'b0, "R1");
    for (int i = 0; i < 80; i++) begin
      x = logic'($urandom_range(0, 1));
      push(x, predict_line(x), (i % 5) != 3);
      if ((i % 5) != 3) check("R6", "recovered bit", d_dout, x);
    end
  endtask

  task automatic t_mismatch_R7();
    logic x;
    do_reset(7'h0F, 7'h70, 1'b0, "R1");
    for (int i = 0; i < 40; i++) begin
      x = logic'($urandom_range(0, 1));
      push(x, predict_line(x), 1'b1);
      if (i >= N) check("R7", "recovered after sync", d_dout, x);
    end
  endtask

  task automatic t_line_error_R8();
    logic x;
    logic line;
    int   errs;
    logic bad [0:N+7];
    do_reset(7'h55, 7'h55, 1'b0, "R1");
    for (int i = 0; i < 10; i++) begin
      x = logic'($urandom_range(0, 1));
      push(x, predict_line(x), 1'b1);
    end
    errs = 0;
    for (int i = 0; i < N + 8; i++) begin
      x = logic'($urandom_range(0, 1));
      line = predict_line(x);
      if (i == 0) line = ~line;
      push(x, line, 1'b1);
      bad[i] = (d_dout !== x);
      if (bad[i]) errs++;
    end
    check("R8", "decoded error count", errs, 3);
    check("R8", "error on arrival", bad[0], 1'b1);
    check("R8", "error at middle tap", bad[M], 1'b1);
    check("R8", "error at last stage", bad[N], 1'b1);
  endtask

  task automatic t_lockup_R9();
    logic outs [0:253];
    int   ones;
    do_reset(7'h00, 7'h00, 1'b0, "R1");
    for (int i = 0; i < 20; i++) begin
      push(1'b0, 1'b0, 1'b1);
      check("R9", "locked zero output", s_dout, 1'b0);
    end
    do_reset(7'h01, 7'h00, 1'b0, "R1");
    for (int i = 0; i < 254; i++) begin
      push(1'b0, 1'b0, 1'b1);
      outs[i] = s_dout;
      if (i == 126) check("R9", "state back to seed after 127", s_state, 7'h01);
    end
    ones = 0;
    for (int i = 0; i < 127; i++) begin
      if (outs[i]) ones++;
      if (outs[i] !== outs[i+127]) check("R9", "period 127 repeat", outs[i+127], outs[i]);
    end
    check("R9", "ones per period", ones, 64);
  endtask

  task automatic t_collide_R10();
    do_reset(7'h21, 7'h4B, 1'b0, "R1");
    push(1'b1, 1'b1, 1'b1);
    push(1'b0, 1'b1, 1'b1);
    do_reset(7'h6E, 7'h19, 1'b1, "R10");
  endtask

  initial begin
    for (int k = 1; k <= N; k++) begin ms[k] = 1'b0; md[k] = 1'b0; end
    es = 1'b0; ed = 1'b0; ev = 1'b0;
    t_reset_R1();
    t_patterns_R2();
    t_gaps_R4();
    t_loopback_R6();
    t_mismatch_R7();
    t_line_error_R8();
    t_lockup_R9();
    t_collide_R10();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule